// File: doc/BRIEF.md
# Address-Permuting Locking Cache Controller

This controller sits between a processor and an untrusted external memory. Its aim is to keep an observer on the memory bus from learning which addresses a program uses. Every logical block address from the processor is translated through an on-chip remap table before it reaches memory. A small fully associative cache absorbs repeated accesses. A line filled on a miss becomes locked and cannot be chosen for eviction, so within one remap epoch no physical location is read twice on behalf of the processor.

When half of the cache lines are locked, the controller stalls the processor and runs a re-permutation pass. First it writes every dirty line back through the current mapping. It then shuffles a copy of the table with a series of LFSR-driven swaps. Finally it moves the memory contents, one chunk at a time, through a small on-chip buffer. Each chunk is gathered from the active half of memory and scattered into the other half at the new positions. At the end of the pass the new table becomes current, the active half flips and every lock is released. The memory port address is one bit wider than a logical address. Its top bit selects the active half.

Top module: `perm_lock_cache`

## Requirements
- R1: After reset, busy is low, the remap table is the identity and the active half is 0. A miss on logical address a therefore reads memory address a, with top bit 0.
- R2: A read or write that hits is acknowledged by cpu_ack in the cycle it is presented and starts no memory access. A read hit returns the line's data on cpu_rdata.
- R3: A miss reads memory at {active half, table[a]} and fills a line that becomes valid, clean and locked. The request then completes as a hit. A write that hits updates the line and marks it dirty.
- R4: The victim line is the lowest-numbered invalid line if there is one. Otherwise it is the lowest-numbered unlocked line. A locked line is never replaced. A dirty victim is first written to memory at {active half, table[tag]}.
- R5: Between two passes, no memory address is read more than once on behalf of the processor.
- R6: A pass starts in the first idle cycle in which 4 of the 8 lines (half) are locked. busy is high from that cycle to the end of the pass, and no request is acknowledged while busy is high. A pass lasts 57 busy cycles: 1 start cycle, 8 flush cycles, 16 shuffle cycles and 32 move cycles.
- R7: A pass writes all dirty lines back through the old mapping, and it preserves the contents of every logical address. A read after any number of passes returns the last value written.
- R8: The pass reads 16 blocks from the active half and writes 16 blocks into the other half, in 4 chunks of 4. The top bit of the memory address used by later misses is inverted.
- R9: At the end of a pass all locks are cleared. The next pass starts only after 4 further misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 4 | Logical block address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | Request completes this cycle |
| busy | output | 1 | Re-permutation pass in progress |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 5 | {half select, physical block} |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, combinational on mem_addr |

## Verification
The hardest situation to reach is a dirty line that is unlocked but still valid and is then evicted, with a pass following before the same address is read again. Only then do eviction write-back, re-permutation and data preservation interact. The stimulus builds it in steps. Two passes first fill all eight lines and leave them unlocked. Two new misses then lock the lowest lines. A write dirties the next unlocked line, and another miss evicts that line. Its address is read once more to trigger a third pass, and the value written must come back. Afterwards a sweep over all sixteen addresses checks that nothing was lost across the passes.

// File: rtl/plc_pkg.sv
package plc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EVICT,
      ST_FILL,
      ST_FLUSH,
      ST_SHUF,
      ST_GATHER,
      ST_SCATTER
   } plc_state_e;
endpackage

// File: rtl/plc_line_store.sv
module plc_line_store #(
   parameter int LINES = 8,
   parameter int AW    = 4,
   parameter int DW    = 8,
   localparam int LW   = $clog2(LINES),
   localparam int CNTW = $clog2(LINES + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   look_addr,
   output logic            hit,
   output logic [LW-1:0]   hit_idx,
   output logic [DW-1:0]   hit_data,
   output logic [LW-1:0]   vic_idx,
   output logic            vic_dirty,
   input  logic [LW-1:0]   rd_idx,
   output logic            rd_dirty,
   output logic [AW-1:0]   rd_tag,
   output logic [DW-1:0]   rd_data,
   input  logic            wr_hit_en,
   input  logic [DW-1:0]   wr_hit_data,
   input  logic            fill_en,
   input  logic [LW-1:0]   fill_idx,
   input  logic [AW-1:0]   fill_tag,
   input  logic [DW-1:0]   fill_data,
   input  logic            clean_en,
   input  logic [LW-1:0]   clean_idx,
   input  logic            unlock_all,
   output logic [CNTW-1:0] lock_cnt
);
   logic [LINES-1:0] valid_q, locked_q, dirty_q, hit_vec;
   logic [AW-1:0]    tag_q  [LINES];
   logic [DW-1:0]    data_q [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_cmp
      assign hit_vec[i] = valid_q[i] && (tag_q[i] == look_addr);
   end

   always_comb begin
      hit     = |hit_vec;
      hit_idx = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = LW'(i);
      end
      hit_data = data_q[hit_idx];
   end

   logic            any_free;
   logic [LW-1:0]   free_idx, unl_idx;
   always_comb begin
      any_free = ~&valid_q;
      free_idx = '0;
      unl_idx  = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (!valid_q[i])  free_idx = LW'(i);
         if (!locked_q[i]) unl_idx  = LW'(i);
      end
      vic_idx   = any_free ? free_idx : unl_idx;
      vic_dirty = valid_q[vic_idx] && dirty_q[vic_idx];
   end

   assign rd_dirty = valid_q[rd_idx] && dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
   assign lock_cnt = CNTW'($countones(locked_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q  <= '0;
         locked_q <= '0;
         dirty_q  <= '0;
      end else begin
         if (unlock_all) locked_q <= '0;
         if (fill_en) begin
            valid_q[fill_idx]  <= 1'b1;
            locked_q[fill_idx] <= 1'b1;
            dirty_q[fill_idx]  <= 1'b0;
         end
         if (wr_hit_en) dirty_q[hit_idx] <= 1'b1;
         if (clean_en)  dirty_q[clean_idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[fill_idx]  <= fill_tag;
         data_q[fill_idx] <= fill_data;
      end
      if (wr_hit_en) data_q[hit_idx] <= wr_hit_data;
   end
endmodule

// File: rtl/plc_remap_table.sv
module plc_remap_table #(
   parameter int              MEM_BLOCKS = 16,
   parameter int              LFSR_W     = 8,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A,
   localparam int             AW         = $clog2(MEM_BLOCKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cur_la,
   output logic [AW-1:0] cur_pa,
   input  logic [AW-1:0] nxt_la,
   output logic [AW-1:0] nxt_pa,
   input  logic          snap_en,
   input  logic          shuf_en,
   input  logic [AW-1:0] shuf_idx,
   input  logic          commit_en
);
   logic [AW-1:0]     cur_q [MEM_BLOCKS];
   logic [AW-1:0]     nxt_q [MEM_BLOCKS];
   logic [LFSR_W-1:0] lfsr_q;
   logic [AW-1:0]     swap_j;

   assign cur_pa = cur_q[cur_la];
   assign nxt_pa = nxt_q[nxt_la];
   assign swap_j = lfsr_q[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lfsr_q <= LFSR_SEED;
      end else if (shuf_en) begin
         lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & LFSR_TAPS)};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < MEM_BLOCKS; e++) begin
            cur_q[e] <= AW'(e);
            nxt_q[e] <= AW'(e);
         end
      end else begin
         if (commit_en) begin
            for (int e = 0; e < MEM_BLOCKS; e++) cur_q[e] <= nxt_q[e];
         end
         if (snap_en) begin
            for (int e = 0; e < MEM_BLOCKS; e++) nxt_q[e] <= cur_q[e];
         end else if (shuf_en) begin
            for (int e = 0; e < MEM_BLOCKS; e++) begin
               if (AW'(e) == shuf_idx)    nxt_q[e] <= nxt_q[swap_j];
               else if (AW'(e) == swap_j) nxt_q[e] <= nxt_q[shuf_idx];
            end
         end
      end
   end
endmodule

// File: rtl/plc_shuffle_buffer.sv
module plc_shuffle_buffer #(
   parameter int  DEPTH = 4,
   parameter int  DW    = 8,
   localparam int KW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [KW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [KW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] slot_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) slot_q[wr_idx] <= wr_data;
   end

   assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/perm_lock_cache.sv
module perm_lock_cache
   import plc_pkg::*;
#(
   parameter int               MEM_BLOCKS = 16,
   parameter int               BUF_BLOCKS = 4,
   parameter int               LINES      = 8,
   parameter int               DW         = 8,
   parameter int               LFSR_W     = 8,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A,
   localparam int              AW         = $clog2(MEM_BLOCKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          cpu_ack,
   output logic          busy,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW:0]   mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   localparam int LW         = $clog2(LINES);
   localparam int KW         = $clog2(BUF_BLOCKS);
   localparam int CHUNKS     = MEM_BLOCKS / BUF_BLOCKS;
   localparam int CW         = $clog2(CHUNKS);
   localparam int CNTW       = $clog2(LINES + 1);
   localparam int LOCK_LIMIT = LINES / 2;

   if ((MEM_BLOCKS & (MEM_BLOCKS - 1)) != 0 || (BUF_BLOCKS & (BUF_BLOCKS - 1)) != 0
       || (LINES & (LINES - 1)) != 0) begin : g_err_pow2
      $error("perm_lock_cache: block and line counts must be powers of two");
   end
   if (CHUNKS < 2 || BUF_BLOCKS < 2) begin : g_err_chunk
      $error("perm_lock_cache: need at least two chunks of at least two blocks");
   end
   if (LINES < 2 || LINES > MEM_BLOCKS) begin : g_err_lines
      $error("perm_lock_cache: line count must lie between 2 and the block count");
   end
   if (LFSR_W <= AW || LFSR_SEED == '0) begin : g_err_lfsr
      $error("perm_lock_cache: LFSR must be wider than the address and seeded non-zero");
   end

   plc_state_e      state_q;
   logic [LW-1:0]   v_idx_q;
   logic [AW-1:0]   cnt_q;
   logic [CW-1:0]   chunk_q;
   logic            region_q;

   logic            hit, vic_dirty, rd_dirty;
   logic [LW-1:0]   hit_idx, vic_idx, rd_idx;
   logic [DW-1:0]   hit_data, rd_data, buf_rdata;
   logic [AW-1:0]   rd_tag, cur_la, cur_pa, nxt_pa, move_la;
   logic [CNTW-1:0] lock_cnt;
   logic            wr_hit_en, fill_en, clean_en, unlock_all;
   logic            snap_en, shuf_en, commit_en, buf_wr_en;
   logic            start_pass, last_line, last_block, last_slot, last_chunk;

   assign move_la    = {chunk_q, cnt_q[KW-1:0]};
   assign rd_idx     = (state_q == ST_FLUSH) ? cnt_q[LW-1:0] : v_idx_q;
   assign last_line  = cnt_q == AW'(LINES - 1);
   assign last_block = cnt_q == AW'(MEM_BLOCKS - 1);
   assign last_slot  = cnt_q[KW-1:0] == KW'(BUF_BLOCKS - 1);
   assign last_chunk = chunk_q == CW'(CHUNKS - 1);
   assign start_pass = (state_q == ST_IDLE) && (lock_cnt >= CNTW'(LOCK_LIMIT));
   assign busy       = start_pass || (state_q == ST_FLUSH) || (state_q == ST_SHUF)
                       || (state_q == ST_GATHER) || (state_q == ST_SCATTER);
   assign cpu_rdata  = hit_data;

   plc_line_store #(.LINES(LINES), .AW(AW), .DW(DW)) u_lines (
      .clk(clk), .rst_n(rst_n), .look_addr(cpu_addr),
      .hit(hit), .hit_idx(hit_idx), .hit_data(hit_data),
      .vic_idx(vic_idx), .vic_dirty(vic_dirty),
      .rd_idx(rd_idx), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_data(rd_data),
      .wr_hit_en(wr_hit_en), .wr_hit_data(cpu_wdata),
      .fill_en(fill_en), .fill_idx(v_idx_q), .fill_tag(cpu_addr), .fill_data(mem_rdata),
      .clean_en(clean_en), .clean_idx(cnt_q[LW-1:0]),
      .unlock_all(unlock_all), .lock_cnt(lock_cnt)
   );

   plc_remap_table #(.MEM_BLOCKS(MEM_BLOCKS), .LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS),
                     .LFSR_SEED(LFSR_SEED)) u_remap (
      .clk(clk), .rst_n(rst_n), .cur_la(cur_la), .cur_pa(cur_pa),
      .nxt_la(move_la), .nxt_pa(nxt_pa), .snap_en(snap_en), .shuf_en(shuf_en),
      .shuf_idx(cnt_q), .commit_en(commit_en)
   );

   plc_shuffle_buffer #(.DEPTH(BUF_BLOCKS), .DW(DW)) u_buf (
      .clk(clk), .wr_en(buf_wr_en), .wr_idx(cnt_q[KW-1:0]), .wr_data(mem_rdata),
      .rd_idx(cnt_q[KW-1:0]), .rd_data(buf_rdata)
   );

   always_comb begin
      cpu_ack    = 1'b0;
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      mem_addr   = '0;
      mem_wdata  = '0;
      wr_hit_en  = 1'b0;
      fill_en    = 1'b0;
      clean_en   = 1'b0;
      unlock_all = 1'b0;
      snap_en    = 1'b0;
      shuf_en    = 1'b0;
      commit_en  = 1'b0;
      buf_wr_en  = 1'b0;
      cur_la     = cpu_addr;
      unique case (state_q)
         ST_IDLE: begin
            if (start_pass) begin
               snap_en = 1'b1;
            end else if (cpu_req && hit) begin
               cpu_ack   = 1'b1;
               wr_hit_en = cpu_we;
            end
         end
         ST_EVICT: begin
            cur_la    = rd_tag;
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {region_q, cur_pa};
            mem_wdata = rd_data;
         end
         ST_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {region_q, cur_pa};
            fill_en  = 1'b1;
         end
         ST_FLUSH: begin
            cur_la    = rd_tag;
            mem_req   = rd_dirty;
            mem_we    = rd_dirty;
            mem_addr  = {region_q, cur_pa};
            mem_wdata = rd_data;
            clean_en  = rd_dirty;
         end
         ST_SHUF: begin
            shuf_en = 1'b1;
         end
         ST_GATHER: begin
            cur_la    = move_la;
            mem_req   = 1'b1;
            mem_addr  = {region_q, cur_pa};
            buf_wr_en = 1'b1;
         end
         ST_SCATTER: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {~region_q, nxt_pa};
            mem_wdata = buf_rdata;
            if (last_slot && last_chunk) begin
               commit_en  = 1'b1;
               unlock_all = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         v_idx_q  <= '0;
         cnt_q    <= '0;
         chunk_q  <= '0;
         region_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_pass) begin
                  state_q <= ST_FLUSH;
                  cnt_q   <= '0;
               end else if (cpu_req && !hit) begin
                  v_idx_q <= vic_idx;
                  state_q <= vic_dirty ? ST_EVICT : ST_FILL;
               end
            end
            ST_EVICT: state_q <= ST_FILL;
            ST_FILL:  state_q <= ST_IDLE;
            ST_FLUSH: begin
               cnt_q <= last_line ? '0 : cnt_q + 1'b1;
               if (last_line) state_q <= ST_SHUF;
            end
            ST_SHUF: begin
               cnt_q <= last_block ? '0 : cnt_q + 1'b1;
               if (last_block) begin
                  state_q <= ST_GATHER;
                  chunk_q <= '0;
               end
            end
            ST_GATHER: begin
               cnt_q <= last_slot ? '0 : cnt_q + 1'b1;
               if (last_slot) state_q <= ST_SCATTER;
            end
            ST_SCATTER: begin
               cnt_q <= last_slot ? '0 : cnt_q + 1'b1;
               if (last_slot) begin
                  if (last_chunk) begin
                     state_q  <= ST_IDLE;
                     region_q <= ~region_q;
                  end else begin
                     chunk_q <= chunk_q + 1'b1;
                     state_q <= ST_GATHER;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/perm_lock_cache_chk.sv
module perm_lock_cache_chk #(
   parameter int AW         = 4,
   parameter int CNTW       = 4,
   parameter int LOCK_LIMIT = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            cpu_ack,
   input logic            mem_req,
   input logic            mem_we,
   input logic [AW:0]     mem_addr,
   input logic [CNTW-1:0] lock_cnt,
   input logic            fill_en
);
   logic [(1<<AW)-1:0] seen_q;
   logic               half_q;
   logic               cpu_read;

   assign cpu_read = mem_req && !mem_we && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= '0;
         half_q <= 1'b0;
      end else begin
         if (busy)          seen_q <= '0;
         else if (cpu_read) seen_q[mem_addr[AW-1:0]] <= 1'b1;
         if ($fell(busy))   half_q <= ~half_q;
      end
   end

   AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cpu_ack); // R6
   AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> !mem_req); // R2
   AST_FILL_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> lock_cnt == $past(lock_cnt) + 1'b1); // R3
   AST_LOCK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      lock_cnt <= CNTW'(LOCK_LIMIT)); // R6
   AST_NO_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_read |-> !seen_q[mem_addr[AW-1:0]]); // R5
   AST_UNLOCK_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> lock_cnt == '0); // R9
   AST_ACTIVE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !busy) |-> mem_addr[AW] == half_q); // R8
endmodule

bind perm_lock_cache perm_lock_cache_chk #(
   .AW(AW), .CNTW(CNTW), .LOCK_LIMIT(LOCK_LIMIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .cpu_ack(cpu_ack), .mem_req(mem_req),
   .mem_we(mem_we), .mem_addr(mem_addr), .lock_cnt(lock_cnt), .fill_en(fill_en)
);

// File: tb/perm_lock_cache_bench.sv
`timescale 1ns/1ps
module perm_lock_cache_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_req = 1'b0, cpu_we = 1'b0;
   logic [3:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata, mem_wdata, mem_rdata;
   logic       cpu_ack, busy, mem_req, mem_we;
   logic [4:0] mem_addr;

   always #5 clk = ~clk;

   perm_lock_cache u_perm_lock_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   logic [7:0] mem_model [32];
   logic [7:0] shadow [16];
   assign mem_rdata = mem_model[mem_addr];
   always @(posedge clk) if (mem_req && mem_we) mem_model[mem_addr] <= mem_wdata;

   int tests = 0, fails = 0;
   int idle_rd, busy_cyc, pass_rd, other_wr, dup_rd = 0;
   logic [4:0]  first_addr;
   logic [15:0] seen = '0;

   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         if (busy) begin
            busy_cyc++;
            seen = '0;
            if (mem_req && !mem_we) pass_rd++;
            if (mem_req && mem_we && idle_rd > 0 && mem_addr[4] != first_addr[4]) other_wr++;
         end else if (mem_req && !mem_we) begin
            if (idle_rd == 0) first_addr = mem_addr;
            idle_rd++;
            if (seen[mem_addr[3:0]]) dup_rd++;
            seen[mem_addr[3:0]] = 1'b1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_op(input bit we, input logic [3:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      idle_rd = 0; busy_cyc = 0; pass_rd = 0; other_wr = 0;
      rd = '0;
      forever begin
         #1;
         if (cpu_ack) begin
            rd = cpu_rdata;
            @(posedge clk);
            #1 cpu_req = 1'b0;
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // {we, addr, wdata, expect miss, expect pass}
   localparam logic [14:0] OPS [20] = '{
      {1'b0, 4'd3,  8'h00, 1'b1, 1'b0}, {1'b0, 4'd3,  8'h00, 1'b0, 1'b0},
      {1'b1, 4'd5,  8'h55, 1'b1, 1'b0}, {1'b0, 4'd5,  8'h00, 1'b0, 1'b0},
      {1'b0, 4'd9,  8'h00, 1'b1, 1'b0}, {1'b1, 4'd3,  8'h33, 1'b0, 1'b0},
      {1'b0, 4'd12, 8'h00, 1'b1, 1'b1}, {1'b0, 4'd3,  8'h00, 1'b0, 1'b0},
      {1'b0, 4'd0,  8'h00, 1'b1, 1'b0}, {1'b0, 4'd1,  8'h00, 1'b1, 1'b0},
      {1'b1, 4'd2,  8'h22, 1'b1, 1'b0}, {1'b0, 4'd7,  8'h00, 1'b1, 1'b1},
      {1'b0, 4'd15, 8'h00, 1'b1, 1'b0}, {1'b0, 4'd3,  8'h00, 1'b1, 1'b0},
      {1'b0, 4'd15, 8'h00, 1'b0, 1'b0}, {1'b0, 4'd9,  8'h00, 1'b0, 1'b0},
      {1'b1, 4'd9,  8'h99, 1'b0, 1'b0}, {1'b0, 4'd5,  8'h00, 1'b1, 1'b0},
      {1'b0, 4'd9,  8'h00, 1'b1, 1'b1}, {1'b0, 4'd15, 8'h00, 1'b0, 1'b0}
   };

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_up();
   end

   initial begin
      logic [7:0] rd;
      for (int p = 0; p < 32; p++) mem_model[p] = (p < 16) ? 8'hA0 + 8'(p) : 8'h00;
      for (int l = 0; l < 16; l++) shadow[l] = 8'hA0 + 8'(l);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(!busy && !cpu_ack && !mem_req, "R1 reset idle", int'(busy), 0);

      for (int i = 0; i < 20; i++) begin
         logic we; logic [3:0] a; logic [7:0] d; logic em, ep;
         {we, a, d, em, ep} = OPS[i];
         do_op(we, a, d, rd);
         if (we) shadow[a] = d;
         else check(rd == shadow[a], "R2/R3 read data", rd, shadow[a]);
         check((idle_rd > 0) == em, "R4 hit/miss pattern (R2 no memory on hit)", idle_rd, em);
         check(busy_cyc == (ep ? 57 : 0), "R6/R9 pass start and length", busy_cyc, ep ? 57 : 0);
         if (ep) begin
            check(pass_rd == 16, "R8 pass reads", pass_rd, 16);
            check(other_wr == 16, "R8 writes to other half", other_wr, 16);
         end
         if (i == 0) check(first_addr == 5'd3, "R1 identity map", first_addr, 3);
         if (i == 8) check(first_addr[4] == 1'b1, "R8 half flips", first_addr[4], 1);
         if (i == 12) check(first_addr[4] == 1'b0, "R8 half flips back", first_addr[4], 0);
         if (i == 18) check(rd == 8'h99, "R4 dirty victim written back", rd, 8'h99);
      end

      for (int l = 0; l < 16; l++) begin
         do_op(1'b0, 4'(l), 8'h00, rd);
         check(rd == shadow[l], "R7 contents preserved", rd, shadow[l]);
      end
      check(dup_rd == 0, "R5 no repeated read in an epoch", dup_rd, 0);

      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      do_op(1'b0, 4'd6, 8'h00, rd);
      check(first_addr == 5'd6, "R1 identity after reset", first_addr, 6);
      finish_up();
   end
endmodule